// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a request into a physical address. Each request brings a segment base and an offset. Their sum, wrapped to 32 bits, is the linear address. When paging is off, the linear address is returned as the physical address one cycle after the request is taken, and memory is not touched.

When paging is on, the linear address is split into three fields. The top ten bits pick a word in a directory of 1024 words. The middle ten bits pick a word in one page table, and that table is named by the directory word. The low twelve bits are the byte offset inside a 4096-byte page. The walker makes two dependent reads through a word-read port that allows one read at a time. The frame number from the second word is joined to the offset. If either word has its present bit clear, the walk stops and reports a fault together with the level that failed.

The request side uses a valid/ready handshake. The walker takes one request at a time, and it returns each result as a single-cycle valid pulse.

Top module: `page_walker`

## Requirements
- R1: After reset, reqReady is 1, while rspValid and memReq are both 0.
- R2: The linear address is reqSegBase + reqOffset modulo 2^32. With pagingOn at 0 when a request is taken, rspValid pulses in the next cycle. In that pulse rspPhys equals the linear address and rspFault is 0, and no memory read is issued.
- R3: With paging on, the first read is at {dirBase, linear[31:22], 2'b00}. Here dirBase is the 20-bit value sampled when the request was taken.
- R4: The second read is at {directory word[31:12], linear[21:12], 2'b00}.
- R5: When both words have bit 0 set, rspPhys is {table word[31:12], linear[11:0]} and rspFault is 0.
- R6: When bit 0 of the directory word is 0, the walk ends with rspFault 1, rspFaultLevel 0 (directory) and rspPhys 0. No second read is made.
- R7: When bit 0 of the table word is 0, the walk ends with rspFault 1, rspFaultLevel 1 (table) and rspPhys 0.
- R8: While a read waits for memValid, memReq stays 1 and memAddr does not change. Only one read is outstanding at a time.
- R9: reqReady is 0 from the cycle after a request is taken up to and including the rspValid cycle. rspValid lasts exactly one cycle. Requests and changes to pagingOn or dirBase during a walk have no effect on it.
- R10: memValid is ignored while memReq is 0.
- R11: For a paged walk, rspValid rises in the cycle after the memValid that ends the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqSegBase | input | 32 | Segment base |
| reqOffset | input | 32 | Offset added to the base |
| pagingOn | input | 1 | 1: walk the tables, 0: bypass |
| dirBase | input | 20 | Page-aligned directory base (frame number) |
| memReq | output | 1 | Read request to memory |
| memAddr | output | 32 | Byte address of the word to read |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data word |
| rspValid | output | 1 | Result pulse |
| rspPhys | output | 32 | Physical address (0 on fault) |
| rspFault | output | 1 | Walk ended on an absent entry |
| rspFaultLevel | output | 1 | 0: directory, 1: table |

## Verification
In bypass mode the result is due exactly one cycle after the acceptance edge. In a walk the result is due one cycle after the edge that delivers the last word. The bench records the cycle count at both points and compares the cycle in which rspValid is seen against that count plus one. A memory model answers each read after a random delay of 0 to 3 cycles and logs every address it serves. Each logged address is checked against the address computed from the requirement. Outputs are sampled on the falling edge, so every registered result is stable when it is read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_DONE = 2'd3
  } ptwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic dirDone;
    logic tblDone;
    logic selTable;
  } ptwStrobe_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pagingOn,
  input  logic       memValid,
  input  logic       entryPresent,
  output logic       reqReady,
  output logic       memReq,
  output logic       rspValid,
  output ptwStrobe_t strobe
);
  ptwState_t stateQ, stateD;

  always_comb begin
    strobe.accept   = (stateQ == ST_IDLE) && reqValid;
    strobe.dirDone  = (stateQ == ST_DIR) && memValid;
    strobe.tblDone  = (stateQ == ST_TBL) && memValid;
    strobe.selTable = (stateQ == ST_TBL);
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) stateD = pagingOn ? ST_DIR : ST_DONE;
      ST_DIR:  if (memValid) stateD = entryPresent ? ST_TBL : ST_DONE;
      ST_TBL:  if (memValid) stateD = ST_DONE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_DIR) || (stateQ == ST_TBL);
  assign rspValid = (stateQ == ST_DONE);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ptwStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         reqSegBase,
  input  logic [ADDR_W-1:0]         reqOffset,
  input  logic [ADDR_W-OFF_W-1:0]   dirBase,
  input  logic [ADDR_W-1:0]         memData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [ADDR_W-1:0]         rspPhys,
  output logic                      rspFault,
  output logic                      rspFaultLevel
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int WORD_B  = OFF_W - IDX_W;   // byte-select bits of a word
  localparam int DIR_LO  = OFF_W + IDX_W;

  logic [ADDR_W-1:0]  linQ, physQ;
  logic [FRAME_W-1:0] dirBaseQ, tblFrameQ;
  logic               faultQ, levelQ;

  wire entryPresent = memData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ      <= '0;
      physQ     <= '0;
      dirBaseQ  <= '0;
      tblFrameQ <= '0;
      faultQ    <= 1'b0;
      levelQ    <= 1'b0;
    end else if (strobe.accept) begin
      linQ     <= reqSegBase + reqOffset;
      physQ    <= reqSegBase + reqOffset;
      dirBaseQ <= dirBase;
      faultQ   <= 1'b0;
      levelQ   <= 1'b0;
    end else if (strobe.dirDone) begin
      tblFrameQ <= memData[ADDR_W-1:OFF_W];
      if (!entryPresent) begin
        faultQ <= 1'b1;
        levelQ <= 1'b0;
        physQ  <= '0;
      end
    end else if (strobe.tblDone) begin
      if (entryPresent) begin
        physQ <= {memData[ADDR_W-1:OFF_W], linQ[OFF_W-1:0]};
      end else begin
        faultQ <= 1'b1;
        levelQ <= 1'b1;
        physQ  <= '0;
      end
    end
  end

  always_comb begin
    if (strobe.selTable)
      memAddr = {tblFrameQ, linQ[DIR_LO-1:OFF_W], {WORD_B{1'b0}}};
    else
      memAddr = {dirBaseQ, linQ[ADDR_W-1:DIR_LO], {WORD_B{1'b0}}};
  end

  assign rspPhys       = physQ;
  assign rspFault      = faultQ;
  assign rspFaultLevel = levelQ;
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqSegBase,
  input  logic [ADDR_W-1:0]       reqOffset,
  input  logic                    pagingOn,
  input  logic [ADDR_W-OFF_W-1:0] dirBase,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memValid,
  input  logic [ADDR_W-1:0]       memData,
  output logic                    rspValid,
  output logic [ADDR_W-1:0]       rspPhys,
  output logic                    rspFault,
  output logic                    rspFaultLevel
);
  ptwStrobe_t strobe;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .pagingOn     (pagingOn),
    .memValid     (memValid),
    .entryPresent (memData[0]),
    .reqReady     (reqReady),
    .memReq       (memReq),
    .rspValid     (rspValid),
    .strobe       (strobe)
  );

  ptw_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqSegBase    (reqSegBase),
    .reqOffset     (reqOffset),
    .dirBase       (dirBase),
    .memData       (memData),
    .memAddr       (memAddr),
    .rspPhys       (rspPhys),
    .rspFault      (rspFault),
    .rspFaultLevel (rspFaultLevel)
  );
endmodule

// File: rtl/page_walker_checker.sv
module page_walker_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic [ADDR_W-1:0]       reqSegBase,
  input logic [ADDR_W-1:0]       reqOffset,
  input logic                    pagingOn,
  input logic                    memReq,
  input logic [ADDR_W-1:0]       memAddr,
  input logic                    memValid,
  input logic                    rspValid,
  input logic [ADDR_W-1:0]       rspPhys,
  input logic                    rspFault
);
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !pagingOn |=>
      rspValid && !memReq && !rspFault &&
      rspPhys == $past(reqSegBase + reqOffset));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPhys == '0);

  assert_hold_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq && !rspValid);
endmodule

bind page_walker page_walker_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqSegBase (reqSegBase),
  .reqOffset  (reqOffset),
  .pagingOn   (pagingOn),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memValid   (memValid),
  .rspValid   (rspValid),
  .rspPhys    (rspPhys),
  .rspFault   (rspFault)
);

// File: tb/page_walker_tb.sv
module page_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqSegBase = '0;
  logic [31:0] reqOffset = '0;
  logic        pagingOn = 1'b0;
  logic [19:0] dirBase = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        rspValid;
  logic [31:0] rspPhys;
  logic        rspFault;
  logic        rspFaultLevel;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int lastCyc = -1;
  bit spurious = 1'b1;
  logic [31:0] addrLog[$];
  logic [31:0] ovr[logic [31:0]];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  page_walker u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = (a ^ 32'h5bd1e995) * 32'h9e3779b1;
    h = h ^ (h >> 15);
    return {h[31:12], 11'd0, (h[7:4] != 4'd0)};
  endfunction

  // memory model: one read at a time, random delay, logs served addresses
  initial begin
    int waitCnt = 0;
    bit armed = 1'b0;
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      if (memReq) begin
        if (!armed) begin armed = 1'b1; waitCnt = $urandom % 4; end
        if (waitCnt == 0) begin
          memValid = 1'b1;
          memData  = memWord(memAddr);
          addrLog.push_back(memAddr);
          lastCyc  = cyc;
          armed    = 1'b0;
        end else waitCnt--;
      end else if (spurious && ($urandom % 5) == 0) begin
        memValid = 1'b1;   // R10: garbage while no read is pending
        memData  = $urandom;
      end
    end
  end

  task automatic runTxn(input logic [31:0] base, input logic [31:0] off, input bit pg,
                        input logic [19:0] db, input bit noise);
    logic [31:0] lin, dA, tA, de, te, expPhys;
    bit expFault, expLvl, busyOk;
    int accCyc, n, expReads;
    lin = base + off;
    dA = {db, lin[31:22], 2'b00};
    de = memWord(dA);
    tA = {de[31:12], lin[21:12], 2'b00};
    te = memWord(tA);
    expFault = 0; expLvl = 0; expReads = 0;
    if (!pg) expPhys = lin;
    else if (!de[0]) begin expFault = 1; expPhys = 0; expReads = 1; end
    else if (!te[0]) begin expFault = 1; expLvl = 1; expPhys = 0; expReads = 2; end
    else begin expPhys = {te[31:12], lin[11:0]}; expReads = 2; end

    @(negedge clk);
    addrLog.delete();
    lastCyc = -1;
    reqSegBase = base; reqOffset = off; pagingOn = pg; dirBase = db; reqValid = 1'b1;
    chk(reqReady === 1'b1, "R9 idle ready", {31'd0, reqReady}, 32'd1);
    accCyc = cyc;
    @(negedge clk);
    reqValid = noise;
    busyOk = 1'b1;
    n = 0;
    forever begin
      if (reqReady !== 1'b0) busyOk = 1'b0;
      if (rspValid === 1'b1 || n > 60) break;
      if (noise) begin
        reqSegBase = $urandom; reqOffset = $urandom; pagingOn = $urandom; dirBase = $urandom;
      end
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    chk(rspValid === 1'b1, "R11 response arrived", {31'd0, rspValid}, 32'd1);
    chk(busyOk, "R9 ready low while busy", {31'd0, busyOk}, 32'd1);
    if (!pg) begin
      chk(cyc == accCyc + 1, "R2 bypass latency", cyc, accCyc + 1);
      chk(addrLog.size() == 0, "R2 no read in bypass", addrLog.size(), 0);
      chk(rspPhys === lin && rspFault === 1'b0, "R2 bypass address", rspPhys, lin);
    end else begin
      chk(cyc == lastCyc + 1, "R11 walk latency", cyc, lastCyc + 1);
      chk(addrLog.size() == expReads, "R6 read count", addrLog.size(), expReads);
      if (addrLog.size() > 0) chk(addrLog[0] === dA, "R3 directory address", addrLog[0], dA);
      if (addrLog.size() > 1) chk(addrLog[1] === tA, "R4 table address", addrLog[1], tA);
      if (!expFault) chk(rspPhys === expPhys && !rspFault, "R5 physical address", rspPhys, expPhys);
      else if (!expLvl) chk(rspFault && !rspFaultLevel && rspPhys == 0, "R6 directory fault",
                            {rspFault, rspFaultLevel, rspPhys[29:0]}, 32'h8000_0000);
      else chk(rspFault && rspFaultLevel && rspPhys == 0, "R7 table fault",
               {rspFault, rspFaultLevel, rspPhys[29:0]}, 32'hC000_0000);
    end
    @(negedge clk);
    chk(!rspValid && reqReady, "R9 single pulse then idle", {30'd0, rspValid, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b1 && rspValid === 1'b0 && memReq === 1'b0, "R1 reset state",
        {29'd0, reqReady, rspValid, memReq}, 32'd4);
    rstN = 1'b1;

    // directed corners
    runTxn(32'hFFFF_FFF0, 32'h0000_0020, 1'b0, 20'h0, 1'b0);   // R2 wrap
    runTxn(32'h0040_0000, 32'h0000_0FFF, 1'b1, 20'h12345, 1'b0); // R5 last byte of page
    runTxn(32'hFFFF_F000, 32'h0000_0FFF, 1'b1, 20'hABCDE, 1'b0); // top indexes
    ovr[{20'h11111, 10'h3, 2'b00}] = 32'h2222_2000;              // R6 absent directory word
    runTxn(32'h00C0_0000, 32'h0000_0123, 1'b1, 20'h11111, 1'b0);
    ovr[{20'h33333, 10'h5, 2'b00}] = 32'h4444_4001;
    ovr[{20'h44444, 10'h7, 2'b00}] = 32'h5555_5000;              // R7 absent table word
    runTxn(32'h0140_0000, 32'h0000_7456, 1'b1, 20'h33333, 1'b0);
    ovr[{20'h44444, 10'h8, 2'b00}] = 32'h6666_6001;
    runTxn(32'h0140_0000, 32'h0000_8ABC, 1'b1, 20'h33333, 1'b1); // R9 noise during walk
    spurious = 1'b0;
    runTxn(32'h1234_5678, 32'h0000_1111, 1'b1, 20'h00042, 1'b0);
    spurious = 1'b1;

    for (int i = 0; i < 400; i++) begin
      runTxn($urandom, $urandom, ($urandom % 5) != 0, $urandom, ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule